// File: doc/BRIEF.md
# Serial Converter Configuration Front End

This block is the device-side digital front end of a serial sampling converter. A host talks to it over four wires: an active-low select, a shift clock, a data input and a data output. In each select cycle the host shifts in an 8-bit configuration byte. At the same time the block shifts out the result of the conversion that the previous select cycle requested. When select returns high after a complete byte, the block commits the new configuration and pulses a start to the conversion engine. The engine later returns a 12-bit result with a done strobe.

All logic runs on the conversion clock `clk`. The select, shift clock and data input are sampled on this clock, and their edges are found by comparing each sample with the previous one. A select fall is acted on only after two further clock edges. This filters out short select glitches. The output word format comes from the configuration that produced the result: MSB-first or LSB-first order, and an 8, 12 or 16 bit length. Bits beyond the programmed length are zero. The tri-state control of the data output is brought out as an enable, `dout_oe`.

Top module: `adc_serial_fe`

## Requirements
- R1: After reset, `dout_oe`, `dout`, `conv_start` and `sample_en` are low, the stored result is zero, and `conv_cfg` is 8'h06 (12-bit, MSB-first).
- R2: A select fall sampled at clock edge k raises `dout_oe` at edge k+2. If `cs_n` is high at any edge before that, the frame is dropped and `dout_oe` stays low.
- R3: The first eight sampled shift-clock rises of a frame shift `din` in first-bit-first, giving bit7 = single-ended, bit6 = odd/sign, bits5:4 = channel select, bit3 = unipolar, bit2 = MSB-first, bits1:0 = word length. Later `din` bits in the same frame have no effect on the committed byte.
- R4: The first output bit is on `dout` as soon as `dout_oe` rises. Each later bit follows a sampled shift-clock fall.
- R5: The word sent in a frame is the result of the conversion started by the previous committed frame, formatted with that frame's configuration byte.
- R6: Word length code 00 or 01 sends the 8 most significant result bits; 10 sends 12 bits; 11 sends the 12 result bits followed by four zeros.
- R7: With bit2 = 0 the word is sent least significant bit first. For the 8-bit length this means result bits 4 up to 11, in that order.
- R8: Every bit sent after the programmed word length is 0.
- R9: The clock edge that first sees `cs_n` high after at least eight rises drops `dout_oe`, loads `conv_cfg` with the captured byte, and raises `conv_start` for exactly one cycle.
- R10: If select rises before the eighth rise, no conversion starts. `conv_cfg` and the stored result are unchanged.
- R11: While a conversion is pending, select falls are ignored. `conv_done` loads `conv_result` as the next word to send, and a new frame needs a fresh select fall after that.
- R12: `sample_en` rises with the 4th sampled rise and falls with the 11th, a window of 7 shift-clock periods. It also falls when the frame ends.
- R13: `dout_oe` is low on every edge after one that sampled `cs_n` high, and `dout` is 0 whenever `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Shift clock from the host |
| din | input | 1 | Serial configuration data from the host |
| dout | output | 1 | Serial result data to the host |
| dout_oe | output | 1 | Output enable for the tri-state `dout` driver |
| sample_en | output | 1 | Analog sampling window to the input stage |
| conv_start | output | 1 | One-cycle request to the conversion engine |
| conv_cfg | output | 8 | Committed configuration byte, held for the engine |
| conv_done | input | 1 | Conversion finished strobe from the engine |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |

## Verification
The bench drives inputs at falling clock edges and samples outputs at falling edges. Every result appears one rising edge after the sampled cause. `dout_oe` is checked low two falling edges after the select drop and high at the third. `conv_start`, the new `conv_cfg` and the drop of `dout_oe` are checked at the falling edge right after select is raised, and `conv_start` is checked low again one cycle later. Each `dout` bit and the `sample_en` level are read just before the bench raises the next shift-clock rise. By then the fall or rise that caused them has been sampled four clock periods earlier. The engine model answers 52 cycles after each start, and the next frame opens only after that answer.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    localparam int CFG_W   = 8;
    localparam int RES_W   = 12;
    localparam int TX_W    = 16;
    localparam int SHORT_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_SHIFT = 2'd2,
        ST_CONV  = 2'd3
    } fe_state_e;

    // Field order matches the order the host sends the bits.
    typedef struct packed {
        logic       single_end;
        logic       odd_sign;
        logic [1:0] chan;
        logic       unipolar;
        logic       msb_first;
        logic [1:0] wlen;
    } fe_cfg_t;

    localparam fe_cfg_t CFG_RESET = fe_cfg_t'(8'h06);

endpackage

// File: rtl/adc_fe_edge.sv
module adc_fe_edge #(
    parameter bit RST_VAL = 1'b0,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);

    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= RST_VAL;
        else        sig_q <= sig;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = sig_q & ~sig;
        end else begin : g_rise
            assign pulse = ~sig_q & sig;
        end
    endgenerate

endmodule

// File: rtl/adc_fe_txfmt.sv
module adc_fe_txfmt
    import adc_fe_pkg::*;
(
    input  logic [RES_W-1:0] result,
    input  logic             msb_first,
    input  logic [1:0]       wlen,
    output logic [TX_W-1:0]  tx_word
);

    localparam int PAD_LONG  = TX_W - RES_W;
    localparam int PAD_SHORT = TX_W - SHORT_W;

    logic [RES_W-1:0] rev;

    genvar gi;
    generate
        for (gi = 0; gi < RES_W; gi++) begin : g_rev
            assign rev[gi] = result[RES_W-1-gi];
        end
    endgenerate

    // tx_word[TX_W-1] leaves first; zero padding always trails.
    always_comb begin
        if (msb_first) begin
            if (wlen[1]) tx_word = {result, {PAD_LONG{1'b0}}};
            else         tx_word = {result[RES_W-1 -: SHORT_W], {PAD_SHORT{1'b0}}};
        end else begin
            if (wlen[1]) tx_word = {rev, {PAD_LONG{1'b0}}};
            else         tx_word = {rev[SHORT_W-1:0], {PAD_SHORT{1'b0}}};
        end
    end

endmodule

// File: rtl/adc_serial_fe.sv
module adc_serial_fe
    import adc_fe_pkg::*;
#(
    parameter int CS_WAIT   = 2,
    parameter int SMP_START = 4,
    parameter int SMP_LEN   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    output logic             dout,
    output logic             dout_oe,
    output logic             sample_en,
    output logic             conv_start,
    output logic [CFG_W-1:0] conv_cfg,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result
);

    localparam int SMP_END = SMP_START + SMP_LEN;
    localparam int CNT_MAX = (SMP_END > CFG_W) ? SMP_END : CFG_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int ARM_W   = $clog2(CS_WAIT + 1);

    localparam logic [CNT_W-1:0] CNT_CFG   = CNT_W'(CFG_W);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] CNT_SON   = CNT_W'(SMP_START);
    localparam logic [CNT_W-1:0] CNT_SOFF  = CNT_W'(SMP_END);
    localparam logic [ARM_W-1:0] ARM_LAST  = ARM_W'(CS_WAIT - 1);

    typedef struct packed {
        fe_state_e         st;
        logic [ARM_W-1:0]  arm;
        logic [CNT_W-1:0]  rises;
        logic [CFG_W-1:0]  cfg_sh;
        fe_cfg_t           cfg;
        logic [RES_W-1:0]  res;
        logic [TX_W-1:0]   tx;
        logic              oe;
        logic              smp;
        logic              start;
    } fe_regs_t;

    fe_regs_t r_q, r_d;

    logic            cs_fall;
    logic            sclk_rise;
    logic            sclk_fall;
    logic [TX_W-1:0] tx_word;

    adc_fe_edge #(.RST_VAL(1'b1), .FALLING(1'b1)) u_cs_fall (
        .clk(clk), .rst_n(rst_n), .sig(cs_n), .pulse(cs_fall)
    );

    adc_fe_edge #(.RST_VAL(1'b0), .FALLING(1'b0)) u_sclk_rise (
        .clk(clk), .rst_n(rst_n), .sig(sclk), .pulse(sclk_rise)
    );

    adc_fe_edge #(.RST_VAL(1'b0), .FALLING(1'b1)) u_sclk_fall (
        .clk(clk), .rst_n(rst_n), .sig(sclk), .pulse(sclk_fall)
    );

    adc_fe_txfmt u_fmt (
        .result    (r_q.res),
        .msb_first (r_q.cfg.msb_first),
        .wlen      (r_q.cfg.wlen),
        .tx_word   (tx_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cs_fall) begin
                    r_d.st  = ST_ARM;
                    r_d.arm = '0;
                end
            end
            ST_ARM: begin
                if (cs_n) begin
                    r_d.st = ST_IDLE;
                end else if (r_q.arm == ARM_LAST) begin
                    r_d.st    = ST_SHIFT;
                    r_d.oe    = 1'b1;
                    r_d.smp   = 1'b0;
                    r_d.tx    = tx_word;
                    r_d.rises = '0;
                end else begin
                    r_d.arm = r_q.arm + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (cs_n) begin
                    r_d.oe  = 1'b0;
                    r_d.smp = 1'b0;
                    if (r_q.rises >= CNT_CFG) begin
                        r_d.cfg   = fe_cfg_t'(r_q.cfg_sh);
                        r_d.start = 1'b1;
                        r_d.st    = ST_CONV;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end else begin
                    if (sclk_rise && (r_q.rises < CNT_TOP)) begin
                        r_d.rises = r_q.rises + 1'b1;
                        if (r_q.rises < CNT_CFG)
                            r_d.cfg_sh = {r_q.cfg_sh[CFG_W-2:0], din};
                        if (r_d.rises == CNT_SON)  r_d.smp = 1'b1;
                        if (r_d.rises == CNT_SOFF) r_d.smp = 1'b0;
                    end
                    if (sclk_fall)
                        r_d.tx = {r_q.tx[TX_W-2:0], 1'b0};
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    r_d.res = conv_result;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cfg <= CFG_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign dout       = r_q.oe & r_q.tx[TX_W-1];
    assign dout_oe    = r_q.oe;
    assign sample_en  = r_q.smp;
    assign conv_start = r_q.start;
    assign conv_cfg   = r_q.cfg;

endmodule

// File: rtl/adc_serial_fe_chk.sv
module adc_serial_fe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       dout,
    input logic       dout_oe,
    input logic       sample_en,
    input logic       conv_start,
    input logic [7:0] conv_cfg
);

    // Written for the default select wait of two edges.
    assert_oe_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> (!$past(cs_n, 1) && !$past(cs_n, 2) && !$past(cs_n, 3)));

    assert_oe_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !dout_oe);

    assert_dout_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> !dout);

    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_start_ends_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(dout_oe) && !dout_oe));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |-> $stable(conv_cfg));

    assert_smp_in_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> dout_oe);

endmodule

bind adc_serial_fe adc_serial_fe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .sample_en  (sample_en),
    .conv_start (conv_start),
    .conv_cfg   (conv_cfg)
);

// File: tb/adc_serial_fe_test.sv
module adc_serial_fe_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;
    localparam int CONV_LAT   = 52;

    logic        clk = 1'b0;
    logic        rst_n, cs_n, sclk, din, conv_done;
    logic [11:0] conv_result;
    logic        dout, dout_oe, sample_en, conv_start;
    logic [7:0]  conv_cfg;

    int checks = 0;
    int fails  = 0;
    int starts = 0;
    bit finished = 0;

    logic [7:0]  cfg_exp_q[$];
    logic [7:0]  fmt_cfg = 8'h06;
    logic [11:0] cur_res = 12'h000;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_fe uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .sample_en(sample_en),
        .conv_start(conv_start), .conv_cfg(conv_cfg),
        .conv_done(conv_done), .conv_result(conv_result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [11:0] res, input logic [7:0] c, input int i);
        int n;
        n = (c[1:0] == 2'b11) ? 16 : (c[1:0] == 2'b10) ? 12 : 8;
        if (i >= n || i >= 12) return 1'b0;
        if (c[2]) return res[11-i];
        if (n == 8) return res[4+i];
        return res[i];
    endfunction

    function automatic logic [11:0] model_res(input int k);
        return 12'hA5C ^ 12'(k * 12'h1F3);
    endfunction

    // Conversion engine model and scoreboard monitor
    initial begin
        conv_done   = 1'b0;
        conv_result = '0;
        forever begin
            @(negedge clk);
            if (conv_start === 1'b1) begin
                logic [7:0] e;
                starts++;
                if (cfg_exp_q.size() == 0) begin
                    chk(0, "R10", "unexpected conv_start", 1, 0);
                end else begin
                    e = cfg_exp_q.pop_front();
                    chk(conv_cfg == e, "R3", "conv_cfg at start", conv_cfg, e);
                end
                @(negedge clk);
                chk(conv_start == 1'b0, "R9", "start pulse width", conv_start, 0);
                repeat (CONV_LAT - 2) @(negedge clk);
                conv_result = model_res(starts);
                conv_done   = 1'b1;
                @(negedge clk);
                conv_done   = 1'b0;
                cur_res     = model_res(starts);
            end
        end
    end

    task automatic xfer(input logic [7:0] cfgb, input int nclk, input logic tail, input int gap);
        logic [11:0] eres;
        logic [7:0]  ecfg;
        int          bad_dout;
        int          bad_smp;
        eres = cur_res;
        ecfg = fmt_cfg;
        bad_dout = 0;
        bad_smp  = 0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(dout_oe == 1'b0, "R2", "oe before wait", dout_oe, 0);
        @(negedge clk);
        chk(dout_oe == 1'b1, "R2", "oe after wait", dout_oe, 1);
        @(negedge clk);
        for (int i = 0; i < nclk; i++) begin
            logic eb;
            logic es;
            eb = exp_bit(eres, ecfg, i);
            es = (i >= 4) && (i < 11);
            if (dout !== eb) begin
                bad_dout++;
                $display("FAIL R5 dout bit %0d actual=%0b expected=%0b", i, dout, eb);
            end
            if (sample_en !== es) begin
                bad_smp++;
                $display("FAIL R12 sample_en before rise %0d actual=%0b expected=%0b", i, sample_en, es);
            end
            din  = (i < 8) ? cfgb[7-i] : tail;
            sclk = 1'b1;
            repeat (HALF_SCLK) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF_SCLK) @(negedge clk);
        end
        checks += 2;
        fails  += (bad_dout != 0) + (bad_smp != 0);
        // R4 R6 R7 R8: word content, checked bit by bit above
        if (nclk >= 8) cfg_exp_q.push_back(cfgb);
        cs_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R13", "oe after select high", dout_oe, 0);
        chk(dout == 1'b0, "R13", "dout while disabled", dout, 0);
        chk(sample_en == 1'b0, "R12", "window closed at frame end", sample_en, 0);
        if (nclk >= 8) begin
            chk(conv_start == 1'b1, "R9", "start raised", conv_start, 1);
            chk(conv_cfg == cfgb, "R9", "conv_cfg loaded", conv_cfg, cfgb);
            fmt_cfg = cfgb;
        end
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        int s0;
        int hi;
        logic [7:0] cfg_before;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0;
        repeat (3) @(negedge clk);
        chk(dout_oe == 0 && dout == 0, "R1", "reset outputs", {dout_oe, dout}, 0);
        chk(conv_start == 0 && sample_en == 0, "R1", "reset strobes", {conv_start, sample_en}, 0);
        chk(conv_cfg == 8'h06, "R1", "reset cfg", conv_cfg, 8'h06);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // A: 16-bit MSB-first request, trailing din ones ignored (R3)
        xfer(8'b1011_0111, 16, 1'b1, 70);
        // B: sends result 1 as 16-bit MSB-first (R5 R6 R8)
        xfer(8'b0100_0010, 16, 1'b0, 70);
        // C: sends result 2 as 12-bit LSB-first (R7)
        xfer(8'b0001_1000, 16, 1'b1, 70);
        // D: sends result 3 as 8-bit LSB-first (R7 R8)
        xfer(8'b1110_0101, 16, 1'b0, 70);
        // E: sends result 4 as 8-bit MSB-first (R6)
        xfer(8'b0000_0110, 14, 1'b1, 70);

        // Abort before the eighth bit (R10)
        s0 = starts;
        cfg_before = conv_cfg;
        xfer(8'b1111_1101, 5, 1'b1, 70);
        chk(starts == s0, "R10", "no start on abort", starts, s0);
        chk(conv_cfg == cfg_before, "R10", "cfg kept on abort", conv_cfg, cfg_before);

        // Select glitch shorter than the wait (R2)
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (dout_oe) hi++;
        end
        chk(hi == 0, "R2", "glitch gives no frame", hi, 0);

        // F: result 5 again after the abort (R10); select drops mid conversion (R11)
        xfer(8'b0011_0010, 16, 1'b0, 5);
        cs_n = 1'b0;
        hi = 0;
        for (int i = 0; i < 70; i++) begin
            @(negedge clk);
            if (dout_oe) hi++;
        end
        chk(hi == 0, "R11", "select fall during conversion ignored", hi, 0);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        // G: result 6 with F format shows conv_done captured (R11)
        xfer(8'b1000_0111, 16, 1'b1, 70);

        chk(cfg_exp_q.size() == 0, "R9", "every commit started", cfg_exp_q.size(), 0);
        chk(starts == 7, "R9", "start count", starts, 7);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule